// File: doc/BRIEF.md
# I/O Window Access Decoder with Test Mode

This block sits between a CPU bus and a small I/O region. It turns CPU accesses to a 32-byte window based at `0x4000` into one-hot read and write strobes for the internal registers, read strobes for two joypad ports, a write strobe for the joypad output latch, a data-bus output-enable, and a read-data selection. The register contents, sound logic and joypad logic are outside the block. Their read values come in on stub data inputs, and the block only routes them.

The test pin passes through the same conditioning chain as the reset pin, so it has the same synchronisation delay. With the test pin low, only a read of the status register at offset `0x15` is served from inside the chip and drives the data bus outward. With the test pin high, every read in the window is served from inside the chip. The joypad read strobes still pulse in test mode, but joypad data is no longer selected. The three extra registers at offsets `0x18` to `0x1A` are reachable only in test mode. Read strobes are combinational while the bus phase is high. Write strobes are one-cycle pulses on the cycle in which the bus phase falls.

Top module: `io_dec`

## Requirements
- R1: The test pin and the reset pin pass through identical chains of `SYNC_STAGES` (default 2) flops. A change on `test_in` driven between clock edges takes effect in decoding after exactly two rising edges.
- R2: With test mode off, a read of offset `0x15` is the only access in the window that raises `bus_oe` and gives `rd_sel` = 1 (internal).
- R3: With test mode on, every read in the window raises `bus_oe` and gives `rd_sel` = 1, and `rd_data` then carries `int_data`.
- R4: A read of offset `0x16` sets `pad_rd_stb[0]` and a read of offset `0x17` sets `pad_rd_stb[1]`, in both modes. Only with test mode off does `rd_sel` become 2 (port 0) or 3 (port 1), with `rd_data` carrying `pad0_data` or `pad1_data`.
- R5: A write to offset `0x16` pulses `pad_wr_stb` in both modes.
- R6: The bits of `reg_rd_stb` and `reg_wr_stb` for offsets `0x18`, `0x19` and `0x1A` can assert only while test mode is on.
- R7: No strobe and no `bus_oe` asserts while `phase` is low, or for any address outside `0x4000`-`0x401F` (all 16 address bits are decoded). In that case `rd_sel` is 0 and `rd_data` is zero.
- R8: A write asserts exactly the `reg_wr_stb` bit of its offset for one clock cycle. That cycle is the one in which `phase` falls, and the address is the one captured while `phase` was high.
- R9: While the conditioned reset is asserted, `reg_wr_stb` and `pad_wr_stb` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronised internally |
| test_in | input | 1 | Test-mode pin, active high, conditioned like reset |
| phase | input | 1 | Bus phase; accesses are valid while high |
| addr | input | 16 | CPU address |
| rnw | input | 1 | 1 = read, 0 = write |
| int_data | input | 8 | Stub read value from internal registers |
| pad0_data | input | 8 | Stub read value from joypad port 0 |
| pad1_data | input | 8 | Stub read value from joypad port 1 |
| reg_rd_stb | output | 32 | One-hot read strobe per window offset |
| reg_wr_stb | output | 32 | One-hot write pulse per window offset |
| pad_rd_stb | output | 2 | Joypad read strobes (bit 0: `0x16`, bit 1: `0x17`) |
| pad_wr_stb | output | 1 | Joypad output-latch write pulse |
| bus_oe | output | 1 | Drive the CPU data bus from the chip |
| rd_sel | output | 2 | Read source: 0 none, 1 internal, 2 port 0, 3 port 1 |
| rd_data | output | 8 | Selected read data |

## Verification
On every clock, the assertions check that `bus_oe` follows only high-phase reads, and that outside test mode it is limited to the status offset. They also check that the extra registers and joypad data selection are locked to the mode, that write pulses are one-hot and follow a falling phase, and that reset silences writes. The exact two-edge latency of the test pin is shown only by the bench's mode-switch scenario. So are the full per-offset strobe maps in both modes, which the bench checks by sweeping every offset and direction. The data values routed to `rd_data` and the one-cycle width of each write pulse are also covered only by the bench.

// File: rtl/io_dec_pkg.sv
`timescale 1ns/1ps
// Shared types for the I/O window decoder.
// Assumes: read source codes are visible at the top as a 2-bit field.
package io_dec_pkg;
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_INT  = 2'd1,
        SEL_PAD0 = 2'd2,
        SEL_PAD1 = 2'd3
    } rd_sel_e;
endpackage

// File: rtl/io_dec_sync.sv
`timescale 1ns/1ps
// Pin conditioning chain: a shift register of STAGES flops.
// Assumes: the same chain is used for reset and test, so both see equal delay;
// the chain has no reset of its own because it produces the reset.
module io_dec_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // shift the pin level through the chain
    always_ff @(posedge clk) begin
        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/io_dec_rd.sv
`timescale 1ns/1ps
// Read-side decode: per-offset read strobes, joypad read strobes, bus
// direction and read source selection.
// Assumes: in_win and off come from a full address compare; all outputs
// are combinational and valid while phase is high.
module io_dec_rd
    import io_dec_pkg::*;
#(
    parameter int OFF_W      = 5,
    parameter int DATA_W     = 8,
    parameter int STATUS_OFF = 21,
    parameter int PAD0_OFF   = 22,
    parameter int PAD1_OFF   = 23,
    parameter int EXT_LO     = 24,
    parameter int EXT_HI     = 26,
    localparam int NREG      = 1 << OFF_W
) (
    input  logic              clk,
    input  logic              rst_q_n,
    input  logic              phase,
    input  logic              rnw,
    input  logic              in_win,
    input  logic [OFF_W-1:0]  off,
    input  logic              test_q,
    input  logic [DATA_W-1:0] int_data,
    input  logic [DATA_W-1:0] pad0_data,
    input  logic [DATA_W-1:0] pad1_data,
    output logic [NREG-1:0]   rd_stb,
    output logic [1:0]        pad_rd_stb,
    output logic              bus_oe,
    output rd_sel_e           rd_sel,
    output logic [DATA_W-1:0] rd_data
);
    logic rd_act;
    assign rd_act = phase & rnw & in_win;

    // one strobe per offset; extra registers only in test mode
    for (genvar i = 0; i < NREG; i++) begin : g_rd
        localparam bit IS_EXT = (i >= EXT_LO) && (i <= EXT_HI);
        if (IS_EXT) begin : g_ext
            assign rd_stb[i] = rd_act & test_q & (off == OFF_W'(i));
        end else begin : g_std
            assign rd_stb[i] = rd_act & (off == OFF_W'(i));
        end
    end

    assign pad_rd_stb[0] = rd_act & (off == OFF_W'(PAD0_OFF));
    assign pad_rd_stb[1] = rd_act & (off == OFF_W'(PAD1_OFF));
    assign bus_oe        = rd_act & (test_q | (off == OFF_W'(STATUS_OFF)));

    // choose the read source; internal wins over the joypad ports
    always_comb begin
        if (bus_oe)             rd_sel = SEL_INT;
        else if (pad_rd_stb[0]) rd_sel = SEL_PAD0;
        else if (pad_rd_stb[1]) rd_sel = SEL_PAD1;
        else                    rd_sel = SEL_NONE;
    end

    // route the selected stub data
    always_comb begin
        case (rd_sel)
            SEL_INT:  rd_data = int_data;
            SEL_PAD0: rd_data = pad0_data;
            SEL_PAD1: rd_data = pad1_data;
            default:  rd_data = '0;
        endcase
    end

    // R2
    oe_status_only_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
        (bus_oe && !test_q) |-> (off == OFF_W'(STATUS_OFF)));
    // R7
    oe_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
        bus_oe |-> (phase && rnw));
    // R4
    pad_sel_mode_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
        (rd_sel == SEL_PAD0 || rd_sel == SEL_PAD1) |-> !test_q);
    // R6
    ext_rd_mode_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
        (|rd_stb[EXT_HI:EXT_LO]) |-> test_q);
    // R7
    rd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
        $onehot0(rd_stb));
endmodule

// File: rtl/io_dec_wr.sv
`timescale 1ns/1ps
// Write-side decode: captures the access during the high phase and emits a
// one-cycle write pulse on the cycle in which phase falls.
// Assumes: phase is synchronous to clk; rst_q_n is the conditioned reset.
module io_dec_wr #(
    parameter int OFF_W    = 5,
    parameter int PAD0_OFF = 22,
    parameter int EXT_LO   = 24,
    parameter int EXT_HI   = 26,
    localparam int NREG    = 1 << OFF_W
) (
    input  logic             clk,
    input  logic             rst_q_n,
    input  logic             phase,
    input  logic             rnw,
    input  logic             in_win,
    input  logic [OFF_W-1:0] off,
    input  logic             test_q,
    output logic [NREG-1:0]  wr_stb,
    output logic             pad_wr_stb
);
    logic             phase_d;
    logic             cap_wr;
    logic [OFF_W-1:0] cap_off;
    logic             fire;

    // remember the phase and the access seen while phase is high
    always_ff @(posedge clk) begin
        if (!rst_q_n) begin
            phase_d <= 1'b0;
            cap_wr  <= 1'b0;
            cap_off <= '0;
        end else begin
            phase_d <= phase;
            if (phase) begin
                cap_wr  <= !rnw && in_win;
                cap_off <= off;
            end
        end
    end

    assign fire = phase_d & ~phase & cap_wr & rst_q_n;

    // one pulse per offset; extra registers only in test mode
    for (genvar i = 0; i < NREG; i++) begin : g_wr
        localparam bit IS_EXT = (i >= EXT_LO) && (i <= EXT_HI);
        if (IS_EXT) begin : g_ext
            assign wr_stb[i] = fire & test_q & (cap_off == OFF_W'(i));
        end else begin : g_std
            assign wr_stb[i] = fire & (cap_off == OFF_W'(i));
        end
    end

    assign pad_wr_stb = fire & (cap_off == OFF_W'(PAD0_OFF));

    // R8
    wr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
        $onehot0(wr_stb));
    // R8
    wr_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
        (|wr_stb) |-> ($past(phase) && !phase));
    // R6
    ext_wr_mode_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
        (|wr_stb[EXT_HI:EXT_LO]) |-> test_q);
    // R9
    wr_reset_quiet_chk: assert property (@(posedge clk)
        !rst_q_n |-> (wr_stb == '0 && !pad_wr_stb));
endmodule

// File: rtl/io_dec.sv
`timescale 1ns/1ps
// Top of the I/O window decoder: conditions the reset and test pins through
// identical chains, compares the address against the window and hands the
// offset to the read and write decoders.
// Assumes: WIN_BASE is aligned to the window size.
module io_dec
    import io_dec_pkg::*;
#(
    parameter int          ADDR_W      = 16,
    parameter int          OFF_W       = 5,
    parameter int          DATA_W      = 8,
    parameter int          SYNC_STAGES = 2,
    parameter logic [15:0] WIN_BASE    = 16'h4000,
    parameter int          STATUS_OFF  = 21,
    parameter int          PAD0_OFF    = 22,
    parameter int          PAD1_OFF    = 23,
    parameter int          EXT_LO      = 24,
    parameter int          EXT_HI      = 26,
    localparam int         NREG        = 1 << OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              test_in,
    input  logic              phase,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rnw,
    input  logic [DATA_W-1:0] int_data,
    input  logic [DATA_W-1:0] pad0_data,
    input  logic [DATA_W-1:0] pad1_data,
    output logic [NREG-1:0]   reg_rd_stb,
    output logic [NREG-1:0]   reg_wr_stb,
    output logic [1:0]        pad_rd_stb,
    output logic              pad_wr_stb,
    output logic              bus_oe,
    output logic [1:0]        rd_sel,
    output logic [DATA_W-1:0] rd_data
);
    logic             rst_q_n;
    logic             test_q;
    logic             in_win;
    logic [OFF_W-1:0] off;
    rd_sel_e          sel;

    io_dec_sync #(.STAGES(SYNC_STAGES)) u_rst_cond (
        .clk(clk), .d(rst_n), .q(rst_q_n));
    io_dec_sync #(.STAGES(SYNC_STAGES)) u_test_cond (
        .clk(clk), .d(test_in), .q(test_q));

    assign in_win = (addr[ADDR_W-1:OFF_W] == WIN_BASE[ADDR_W-1:OFF_W]);
    assign off    = addr[OFF_W-1:0];

    io_dec_rd #(
        .OFF_W(OFF_W), .DATA_W(DATA_W), .STATUS_OFF(STATUS_OFF),
        .PAD0_OFF(PAD0_OFF), .PAD1_OFF(PAD1_OFF),
        .EXT_LO(EXT_LO), .EXT_HI(EXT_HI)
    ) u_rd (
        .clk(clk), .rst_q_n(rst_q_n), .phase(phase), .rnw(rnw),
        .in_win(in_win), .off(off), .test_q(test_q),
        .int_data(int_data), .pad0_data(pad0_data), .pad1_data(pad1_data),
        .rd_stb(reg_rd_stb), .pad_rd_stb(pad_rd_stb), .bus_oe(bus_oe),
        .rd_sel(sel), .rd_data(rd_data));

    io_dec_wr #(
        .OFF_W(OFF_W), .PAD0_OFF(PAD0_OFF),
        .EXT_LO(EXT_LO), .EXT_HI(EXT_HI)
    ) u_wr (
        .clk(clk), .rst_q_n(rst_q_n), .phase(phase), .rnw(rnw),
        .in_win(in_win), .off(off), .test_q(test_q),
        .wr_stb(reg_wr_stb), .pad_wr_stb(pad_wr_stb));

    assign rd_sel = sel;

    // R7
    no_win_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
        !in_win |-> (reg_rd_stb == '0 && pad_rd_stb == 2'b00 && !bus_oe));
endmodule

// File: tb/io_dec_test.sv
`timescale 1ns/1ps
module io_dec_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        test_in = 1'b0;
    logic        phase = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic        rnw = 1'b1;
    logic [7:0]  int_data  = 8'hA5;
    logic [7:0]  pad0_data = 8'h3C;
    logic [7:0]  pad1_data = 8'hC3;
    logic [31:0] reg_rd_stb, reg_wr_stb;
    logic [1:0]  pad_rd_stb, rd_sel;
    logic        pad_wr_stb, bus_oe;
    logic [7:0]  rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    io_dec uut (
        .clk(clk), .rst_n(rst_n), .test_in(test_in), .phase(phase),
        .addr(addr), .rnw(rnw), .int_data(int_data), .pad0_data(pad0_data),
        .pad1_data(pad1_data), .reg_rd_stb(reg_rd_stb), .reg_wr_stb(reg_wr_stb),
        .pad_rd_stb(pad_rd_stb), .pad_wr_stb(pad_wr_stb), .bus_oe(bus_oe),
        .rd_sel(rd_sel), .rd_data(rd_data));

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit in_w(logic [15:0] a);
        return a[15:5] == 11'h200;
    endfunction

    function automatic bit is_ext(int o);
        return o >= 24 && o <= 26;
    endfunction

    // expected read-strobe vector
    function automatic logic [31:0] e_rd(bit t, logic [15:0] a, bit r);
        logic [31:0] v = '0;
        if (r && in_w(a) && (!is_ext(a[4:0]) || t)) v[a[4:0]] = 1'b1;
        return v;
    endfunction

    // expected write-pulse vector
    function automatic logic [31:0] e_wr(bit t, logic [15:0] a, bit r);
        logic [31:0] v = '0;
        if (!r && in_w(a) && (!is_ext(a[4:0]) || t)) v[a[4:0]] = 1'b1;
        return v;
    endfunction

    function automatic logic [1:0] e_sel(bit t, logic [15:0] a, bit r);
        if (!r || !in_w(a)) return 2'd0;
        if (t || a[4:0] == 5'h15) return 2'd1;
        if (a[4:0] == 5'h16) return 2'd2;
        if (a[4:0] == 5'h17) return 2'd3;
        return 2'd0;
    endfunction

    function automatic logic [7:0] e_dat(logic [1:0] s);
        case (s)
            2'd1: return 8'hA5;
            2'd2: return 8'h3C;
            2'd3: return 8'hC3;
            default: return 8'h00;
        endcase
    endfunction

    // one full bus access: high phase, falling phase, following cycle
    task automatic access(bit t, logic [15:0] a, bit r, bit rst_on);
        logic [1:0] s = e_sel(t, a, r);
        logic [1:0] pr;
        pr[0] = r && in_w(a) && a[4:0] == 5'h16;
        pr[1] = r && in_w(a) && a[4:0] == 5'h17;
        @(negedge clk); phase = 1'b1; addr = a; rnw = r;
        #1;
        chk("R6 read strobes", reg_rd_stb, e_rd(t, a, r));
        chk("R4 pad read strobes", 32'(pad_rd_stb), 32'(pr));
        chk(t ? "R3 bus_oe" : "R2 bus_oe", 32'(bus_oe), 32'(s == 2'd1));
        chk("R4 rd_sel", 32'(rd_sel), 32'(s));
        chk("R3 rd_data", 32'(rd_data), 32'(e_dat(s)));
        @(negedge clk); phase = 1'b0;
        #1;
        chk(rst_on ? "R9 write during reset" : "R8 write pulse",
            reg_wr_stb, rst_on ? 32'h0 : e_wr(t, a, r));
        chk("R5 pad write", 32'(pad_wr_stb),
            32'(!rst_on && !r && in_w(a) && a[4:0] == 5'h16));
        chk("R7 low phase reads", 32'({reg_rd_stb != 0, bus_oe, pad_rd_stb}), 32'h0);
        @(negedge clk);
        #1;
        chk("R8 pulse width", reg_wr_stb, 32'h0);
    endtask

    task automatic set_mode(bit t);
        @(negedge clk); test_in = t;
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        // R9: writes silenced while reset held
        repeat (4) @(negedge clk);
        chk("R9 reset state", reg_wr_stb, 32'h0);
        access(1'b0, 16'h4016, 1'b0, 1'b1);
        access(1'b0, 16'h4003, 1'b0, 1'b1);
        @(negedge clk); rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // full sweep in both modes and both directions
        for (int t = 0; t < 2; t++) begin
            set_mode(t[0]);
            for (int o = 0; o < 32; o++) begin
                access(t[0], 16'h4000 | 16'(o), 1'b1, 1'b0);
                access(t[0], 16'h4000 | 16'(o), 1'b0, 1'b0);
            end
            // R7: neighbours and aliases outside the window
            access(t[0], 16'h3FFF, 1'b1, 1'b0);
            access(t[0], 16'h4020, 1'b0, 1'b0);
            access(t[0], 16'hC015, 1'b1, 1'b0);
            access(t[0], 16'h0016, 1'b0, 1'b0);
        end

        // R1: test pin takes effect after exactly two rising edges
        set_mode(1'b0);
        @(negedge clk); test_in = 1'b1; phase = 1'b1; addr = 16'h4000; rnw = 1'b1;
        #1 chk("R1 no edge yet", 32'(bus_oe), 32'h0);
        @(negedge clk);
        #1 chk("R1 after one edge", 32'(bus_oe), 32'h0);
        @(negedge clk);
        #1 chk("R1 after two edges", 32'(bus_oe), 32'h1);
        @(negedge clk); phase = 1'b0; rnw = 1'b1;
        repeat (2) @(negedge clk);

        // random accesses, half aimed at the window
        for (int blk = 0; blk < 6; blk++) begin
            bit t = blk[0];
            set_mode(t);
            for (int k = 0; k < 60; k++) begin
                logic [15:0] a = 16'($urandom);
                if ($urandom % 2 == 0) a = 16'h4000 | 16'($urandom % 32);
                access(t, a, 1'($urandom), 1'b0);
            end
        end
        finish_run();
    end
endmodule